// File: doc/BRIEF.md
# UART Baud Rate Generator

This block derives the two timing strobes that a UART transmitter and receiver need from a single reference clock. A 16-bit clock divisor turns the reference clock into a sample strobe, and an 8-bit bit divisor counts those strobes to mark each bit period. The bit rate is therefore clock / (P × CD × (BD + 1)). P is 1, or 8 when the optional prescaler is selected. CD is the clock divisor and BD is the bit divisor.

All configuration arrives through single-cycle register writes on a simple address/data port. Any accepted configuration write restarts every counter in the same clock edge. As a result, the strobes never show a shortened or stretched period after reprogramming. The bit divisor has a floor of 4, so a bit always spans at least five sample strobes.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the clock divisor is 0, the bit divisor is 4 and the prescaler is off, so neither strobe asserts until the clock divisor is written.
- R2: A write with `wr_addr` = 0x18 loads the clock divisor from `wr_data[15:0]`. With the prescaler off and a clock divisor N ≥ 1, `sample_tick` is high for one cycle in every N.
- R3: While the clock divisor is 0, neither `sample_tick` nor `bit_tick` asserts.
- R4: A clock divisor of 1 makes `sample_tick` high on every cycle in which the prescaled enable is high, which is every cycle when the prescaler is off.
- R5: A write with `wr_addr` = 0x34 loads the bit divisor B from `wr_data[7:0]`. `bit_tick` asserts only together with `sample_tick`, once every B+1 sample strobes, on the strobe where the bit counter wraps from B to 0.
- R6: A bit divisor write with a value below 4 stores 4.
- R7: Bit 0 of a write with `wr_addr` = 0x04 selects the divide-by-8 prescaler. With it set, `sample_tick` occurs once every 8×N cycles.
- R8: Every write to 0x04, 0x18 or 0x34 restarts both counters and the prescaler. Counting the cycle after the write edge as cycle 0, the first `sample_tick` falls in cycle P×N−1 and the first `bit_tick` falls in cycle P×N×(B+1)−1.
- R9: Writes to any other offset, and bus values presented while `wr_en` is low, change no setting and do not restart the strobe sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit-period strobe |

## Verification
A corrupted divisor, prescaler or bit counter shows at the ports as a strobe in the wrong cycle. The bench therefore compares both strobes against a closed-form cycle index on every cycle of each window. A missing restart or a wrongly stored setting is caught at the first expected sample strobe, which comes at most P×N cycles after the write. A bit-counter fault is caught within one bit period. A write that should have been ignored but changed state is caught by the phase break it causes in the sequence that runs on.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int CD_W    = 16;
    localparam int BD_W    = 8;
    localparam int PRE_DIV = 8;

    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CD   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_BDIV = 8'h34;
    localparam logic [BD_W-1:0]   BDIV_MIN = 8'd4;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_CD,
        SEL_BDIV
    } reg_sel_e;

    typedef struct packed {
        logic            presel;
        logic [CD_W-1:0] cd;
        logic [BD_W-1:0] bdiv;
    } baud_cfg_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_MODE: return SEL_MODE;
            OFS_CD:   return SEL_CD;
            OFS_BDIV: return SEL_BDIV;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [BD_W-1:0] clamp_bdiv(input logic [BD_W-1:0] v);
        return (v < BDIV_MIN) ? BDIV_MIN : v;
    endfunction
endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output baud_cfg_t         cfg,
    output logic              restart
);
    reg_sel_e  sel;
    baud_cfg_t cfg_q;

    assign sel     = decode_addr(wr_addr);
    assign restart = wr_en && (sel != SEL_NONE);
    assign cfg     = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.presel <= 1'b0;
            cfg_q.cd     <= '0;
            cfg_q.bdiv   <= BDIV_MIN;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE: cfg_q.presel <= wr_data[0];
                SEL_CD:   cfg_q.cd     <= wr_data[CD_W-1:0];
                SEL_BDIV: cfg_q.bdiv   <= clamp_bdiv(wr_data[BD_W-1:0]);
                default:  ;
            endcase
        end
    end

    assert_bdiv_floor_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_q.bdiv >= BDIV_MIN);
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic sel,
    output logic en_out
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] pcnt;

    assign en_out = sel ? (pcnt == LAST) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt <= '0;
        end else if (sel) begin
            pcnt <= (pcnt == LAST) ? '0 : pcnt + W'(1);
        end
    end

    assert_prescale_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (sel && en_out) |=> (!en_out || !sel));
endmodule

// File: rtl/baud_sample_div.sv
module baud_sample_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         en,
    input  logic [W-1:0] cd,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic         active;

    assign active = (cd != '0);
    assign tick   = active && en && (cnt == cd - W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (en && active) begin
            cnt <= tick ? '0 : cnt + W'(1);
        end
    end

    assert_unit_cd_R4: assert property (@(posedge clk) disable iff (rst)
        (cd == W'(1) && en) |-> tick);
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         sample_tick,
    input  logic [W-1:0] bdiv,
    output logic         bit_tick
);
    logic [W-1:0] bcnt;

    assign bit_tick = sample_tick && (bcnt == bdiv);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            bcnt <= '0;
        end else if (sample_tick) begin
            bcnt <= (bcnt == bdiv) ? '0 : bcnt + W'(1);
        end
    end

    assert_bit_on_sample_R5: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        bcnt <= bdiv);
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sample_tick,
    output logic              bit_tick
);
    baud_cfg_t cfg;
    logic      restart;
    logic      pre_en;

    baud_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .restart (restart)
    );

    baud_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .sel     (cfg.presel),
        .en_out  (pre_en)
    );

    baud_sample_div #(.W(CD_W)) u_sdiv (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .en      (pre_en),
        .cd      (cfg.cd),
        .tick    (sample_tick)
    );

    baud_bit_div #(.W(BD_W)) u_bdiv (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .sample_tick (sample_tick),
        .bdiv        (cfg.bdiv),
        .bit_tick    (bit_tick)
    );

    assert_cd_zero_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg.cd == '0) |-> (!sample_tick && !bit_tick));
    assert_restart_no_bit_R8: assert property (@(posedge clk) disable iff (rst)
        restart |=> !bit_tick);
endmodule

// File: tb/tb_uart_baud_gen.sv
module tb_uart_baud_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        sample_tick;
    logic        bit_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    uart_baud_gen dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Compares both strobes on every cycle against the closed-form index.
    task automatic run_window(input int p, input int n, input int b,
                              input int i0, input int len, input string req);
        int s_bad = 0;
        int b_bad = 0;
        for (int k = 0; k < len; k++) begin
            int  i = i0 + k;
            bit  es = (n != 0) && (((i + 1) % (p * n)) == 0);
            bit  eb = (n != 0) && (((i + 1) % (p * n * (b + 1))) == 0);
            if (sample_tick !== es) s_bad++;
            if (bit_tick !== eb) b_bad++;
            @(negedge clk);
        end
        check(s_bad == 0, {req, " sample_tick mismatched cycles"}, s_bad, 0);
        check(b_bad == 0, {req, " bit_tick mismatched cycles"}, b_bad, 0);
    endtask

    task automatic t_reset();
        int ticks = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            ticks += int'(sample_tick) + int'(bit_tick);
        end
        check(ticks == 0, "R1 idle after reset", ticks, 0);
        write_reg(8'h18, 32'd2);
        run_window(1, 2, 4, 0, 60, "R1 default bit divisor");
    endtask

    task automatic t_basic();
        write_reg(8'h34, 32'd4);
        write_reg(8'h18, 32'd3);
        run_window(1, 3, 4, 0, 90, "R2 R5 cd=3 bd=4");
        write_reg(8'h34, 32'd9);
        run_window(1, 3, 9, 0, 120, "R5 bd=9");
    endtask

    task automatic t_cd_one();
        write_reg(8'h34, 32'd5);
        write_reg(8'h18, 32'd1);
        run_window(1, 1, 5, 0, 40, "R4 cd=1");
    endtask

    task automatic t_cd_zero();
        write_reg(8'h18, 32'd0);
        run_window(1, 0, 5, 0, 100, "R3 cd=0");
    endtask

    task automatic t_clamp();
        write_reg(8'h18, 32'd2);
        write_reg(8'h34, 32'd1);
        run_window(1, 2, 4, 0, 60, "R6 bd write 1");
        write_reg(8'h34, 32'd0);
        run_window(1, 2, 4, 0, 60, "R6 bd write 0");
    endtask

    task automatic t_prescale();
        write_reg(8'h18, 32'd2);
        write_reg(8'h34, 32'd4);
        write_reg(8'h04, 32'd1);
        run_window(8, 2, 4, 0, 200, "R7 prescaler on");
        write_reg(8'h04, 32'd0);
        run_window(1, 2, 4, 0, 40, "R7 prescaler off");
    endtask

    task automatic t_restart();
        write_reg(8'h18, 32'd5);
        run_window(1, 5, 4, 0, 3, "R8 before rewrite");
        write_reg(8'h18, 32'd5);
        run_window(1, 5, 4, 0, 100, "R8 restart on rewrite");
    endtask

    task automatic t_ignored();
        write_reg(8'h18, 32'd4);
        run_window(1, 4, 4, 0, 3, "R9 before stray writes");
        wr_en = 1'b1; wr_addr = 8'h20; wr_data = 32'd1;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 8'h18; wr_data = 32'd7;
        @(negedge clk);
        run_window(1, 4, 4, 5, 80, "R9 stray writes ignored");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_cd_one();
        t_cd_zero();
        t_clamp();
        t_prescale();
        t_restart();
        t_ignored();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule